// File: doc/BRIEF.md
# Write Protect and Program Cycle Controller

This block is the write side of a small serial non-volatile word memory. It receives already-decoded command strobes from a serial front end. Those strobes are: enable writes, disable writes, single-word write, page-buffer load and page write. It holds a software write-enable latch and accepts a write only when the latch is set, the hardware reset pin is low and no programming cycle is running.

An accepted write starts a timed erase-then-program cycle into a 512 x 16 behavioural array. The cycle covers either one word or up to eight buffered words of one aligned page. While the cycle runs, the ready output is held low regardless of chip select. Raising the reset pin during a cycle aborts it at once, releases ready and leaves the target words filled with ones.

A separate monitor watches the chip-select level. It flags any select that follows too short a deselected gap. A registered read port gives access to the array.

Top module: `prog_ctrl`

## Requirements
- R1: The write-enable latch is clear after power-on reset. A disable strobe clears it and an enable strobe sets it. When both strobes arrive in the same cycle, disable wins.
- R2: A write or page write request is dropped when the latch is clear, when the reset pin is high, or when a cycle is already running. After a dropped request, `rdy_o` stays high and the array is unchanged.
- R3: Enable and disable strobes and the read port act normally while the reset pin is high and while a cycle runs.
- R4: After an accepted write, `rdy_o` is low from the next cycle for exactly PROG_CYCLES cycles. The new data is readable once `rdy_o` is high again.
- R5: `rdy_o` depends only on the programming cycle and never on `cs_i`.
- R6: When `hw_rst_i` is high during a cycle, `rdy_o` returns high on the next cycle. Every target word of that cycle then reads 16'hFFFF.
- R7: Each page-load strobe appends `data_i` to the page buffer. At most 8 words are kept and further loads are dropped. A page write places buffered word k at address {addr[8:3], addr[2:0]+k mod 8}. Every page write request empties the buffer, accepted or not. If a write and a page write arrive in the same cycle, the single write is taken.
- R8: The write-enable latch is not cleared by the completion of a write cycle.
- R9: `viol_o` pulses for one cycle, one clock after `cs_i` is first sampled low, when `cs_i` had been sampled high on fewer than CS_MIN_CYC consecutive edges before that.
- R10: `rd_data_o` shows the word at `rd_addr_i` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_i | input | 1 | Hardware reset pin: blocks writes and aborts a running cycle |
| cs_i | input | 1 | Chip-select level, high means deselected |
| wren_i | input | 1 | Enable-writes strobe |
| wrds_i | input | 1 | Disable-writes strobe |
| wr_i | input | 1 | Single-word write strobe |
| pld_i | input | 1 | Page-buffer load strobe |
| pgwr_i | input | 1 | Page write strobe |
| addr_i | input | 9 | Write target address |
| data_i | input | 16 | Write data or page-load data |
| rd_addr_i | input | 9 | Read port address |
| rd_data_o | output | 16 | Read port data, registered |
| rdy_o | output | 1 | High when idle, low during a programming cycle |
| viol_o | output | 1 | One-cycle pulse on a too-short deselect gap |

## Verification
The main function is exercised in several ways:
- single-word writes with the latch set, with the latch cleared, with the reset pin high and during a busy cycle. These separate the three gating conditions from one another.
- page writes with a partial buffer starting mid-page, which shows the offset wraparound.
- page writes with an overfilled buffer, which shows that loads past eight are dropped.
- cycles aborted both on single words and on pages. Reading back all-ones data and neighbouring untouched words tells an abort apart from a normal commit.
- chip-select toggling during busy, which shows that ready ignores select.
- short and long deselect gaps, which pin down the violation threshold.

// File: rtl/pc_pkg.sv
package pc_pkg;
   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,
      EV_RUN   = 2'd1,
      EV_DONE  = 2'd2,
      EV_ABORT = 2'd3
   } pc_ev_e;
endpackage

// File: rtl/pc_guard.sv
module pc_guard (
   input  logic clk,
   input  logic por_n,
   input  logic wren_i,
   input  logic wrds_i,
   input  logic wr_i,
   input  logic pgwr_i,
   input  logic hw_rst_i,
   input  logic busy_i,
   output logic wel_o,
   output logic start_o,
   output logic start_page_o
);
   logic wel_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      wel_q <= 1'b0;
      else if (wrds_i) wel_q <= 1'b0;
      else if (wren_i) wel_q <= 1'b1;
   end

   always_comb begin
      start_o      = (wr_i | pgwr_i) & wel_q & ~hw_rst_i & ~busy_i;
      start_page_o = start_o & ~wr_i;
   end

   assign wel_o = wel_q;
endmodule

// File: rtl/pc_timer.sv
module pc_timer
   import pc_pkg::*;
#(
   parameter int CYCLES = 625000
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   start_i,
   input  logic   hw_rst_i,
   output logic   busy_o,
   output pc_ev_e ev_o
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (hw_rst_i || cnt_q == '0) busy_q <= 1'b0;
         else                         cnt_q  <= cnt_q - 1'b1;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(CYCLES - 1);
      end
   end

   always_comb begin
      if (!busy_q)          ev_o = EV_IDLE;
      else if (hw_rst_i)    ev_o = EV_ABORT;
      else if (cnt_q == '0) ev_o = EV_DONE;
      else                  ev_o = EV_RUN;
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/pc_gap_mon.sv
module pc_gap_mon #(
   parameter int MIN_CYC = 32
) (
   input  logic clk,
   input  logic por_n,
   input  logic cs_i,
   output logic viol_o
);
   localparam int HW = $clog2(MIN_CYC + 1);
   localparam logic [HW-1:0] HMAX = HW'(MIN_CYC);

   logic          cs_q;
   logic [HW-1:0] hi_q;
   logic          viol_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cs_q   <= 1'b0;
         hi_q   <= HMAX;
         viol_q <= 1'b0;
      end else begin
         cs_q   <= cs_i;
         viol_q <= ~cs_i & cs_q & (hi_q < HMAX);
         if (!cs_i)            hi_q <= '0;
         else if (hi_q < HMAX) hi_q <= hi_q + 1'b1;
      end
   end

   assign viol_o = viol_q;
endmodule

// File: rtl/pc_array.sv
module pc_array #(
   parameter int AW = 9,
   parameter int DW = 16,
   parameter int PW = 8
) (
   input  logic                   clk,
   input  logic                   commit_i,
   input  logic                   corrupt_i,
   input  logic [PW-1:0][AW-1:0]  job_addr_i,
   input  logic [PW-1:0][DW-1:0]  job_data_i,
   input  logic [PW-1:0]          job_vld_i,
   input  logic [AW-1:0]          rd_addr_i,
   output logic [DW-1:0]          rd_data_o
);
   localparam int DEPTH = 1 << AW;
   localparam logic [DW-1:0] FILL = '1;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int k = 0; k < PW; k++) begin
         if (job_vld_i[k] && (commit_i || corrupt_i))
            mem[job_addr_i[k]] <= corrupt_i ? FILL : job_data_i[k];
      end
      rd_data_o <= mem[rd_addr_i];
   end
endmodule

// File: rtl/prog_ctrl.sv
module prog_ctrl
   import pc_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int PAGE_WORDS  = 8,
   parameter int PROG_CYCLES = 625000,
   parameter int CS_MIN_CYC  = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_rst_i,
   input  logic              cs_i,
   input  logic              wren_i,
   input  logic              wrds_i,
   input  logic              wr_i,
   input  logic              pld_i,
   input  logic              pgwr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rdy_o,
   output logic              viol_o
);
   localparam int OFS_W = $clog2(PAGE_WORDS);
   localparam int CNT_W = $clog2(PAGE_WORDS + 1);
   localparam logic [CNT_W-1:0] PMAX = CNT_W'(PAGE_WORDS);

   if (PAGE_WORDS < 2 || (1 << OFS_W) != PAGE_WORDS) begin : g_bad_page
      $error("PAGE_WORDS must be a power of two of at least 2");
   end
   if (OFS_W >= ADDR_W) begin : g_bad_addr
      $error("page must be smaller than the array");
   end
   if (PROG_CYCLES < 1 || CS_MIN_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be positive");
   end

   logic   wel, start, start_page, busy;
   pc_ev_e ev;

   logic [PAGE_WORDS-1:0][DATA_W-1:0] pbuf_q;
   logic [CNT_W-1:0]                  pcnt_q;
   logic [PAGE_WORDS-1:0][ADDR_W-1:0] job_addr_q;
   logic [PAGE_WORDS-1:0][DATA_W-1:0] job_data_q;
   logic [PAGE_WORDS-1:0]             job_vld_q;

   pc_guard u_guard (
      .clk          (clk),
      .por_n        (por_n),
      .wren_i       (wren_i),
      .wrds_i       (wrds_i),
      .wr_i         (wr_i),
      .pgwr_i       (pgwr_i),
      .hw_rst_i     (hw_rst_i),
      .busy_i       (busy),
      .wel_o        (wel),
      .start_o      (start),
      .start_page_o (start_page)
   );

   pc_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk      (clk),
      .por_n    (por_n),
      .start_i  (start),
      .hw_rst_i (hw_rst_i),
      .busy_o   (busy),
      .ev_o     (ev)
   );

   pc_gap_mon #(.MIN_CYC(CS_MIN_CYC)) u_gap (
      .clk    (clk),
      .por_n  (por_n),
      .cs_i   (cs_i),
      .viol_o (viol_o)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pcnt_q <= '0;
      end else if (pgwr_i) begin
         pcnt_q <= '0;
      end else if (pld_i && pcnt_q < PMAX) begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end

   for (genvar k = 0; k < PAGE_WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (pld_i && !pgwr_i && pcnt_q == CNT_W'(k))
            pbuf_q[k] <= data_i;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            job_vld_q[k]  <= 1'b0;
            job_addr_q[k] <= '0;
            job_data_q[k] <= '0;
         end else if (start) begin
            job_addr_q[k] <= {addr_i[ADDR_W-1:OFS_W],
                              addr_i[OFS_W-1:0] + OFS_W'(k)};
            if (start_page) begin
               job_vld_q[k]  <= CNT_W'(k) < pcnt_q;
               job_data_q[k] <= pbuf_q[k];
            end else begin
               job_vld_q[k]  <= (k == 0);
               job_data_q[k] <= data_i;
            end
         end
      end
   end

   pc_array #(.AW(ADDR_W), .DW(DATA_W), .PW(PAGE_WORDS)) u_array (
      .clk        (clk),
      .commit_i   (ev == EV_DONE),
      .corrupt_i  (ev == EV_ABORT),
      .job_addr_i (job_addr_q),
      .job_data_i (job_data_q),
      .job_vld_i  (job_vld_q),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o)
   );

   assign rdy_o = ~busy;
endmodule

// File: rtl/pc_checker.sv
module pc_checker (
   input logic clk,
   input logic por_n,
   input logic hw_rst_i,
   input logic cs_i,
   input logic wren_i,
   input logic wrds_i,
   input logic wr_i,
   input logic pgwr_i,
   input logic rdy_o,
   input logic viol_o,
   input logic wel
);
   a_r1_disable_clears: assert property (@(posedge clk) disable iff (!por_n)
      wrds_i |=> !wel);
   a_r1_enable_sets: assert property (@(posedge clk) disable iff (!por_n)
      (wren_i && !wrds_i) |=> wel);
   a_r2_blocked_stays_ready: assert property (@(posedge clk) disable iff (!por_n)
      ((wr_i || pgwr_i) && (!wel || hw_rst_i) && rdy_o) |=> rdy_o);
   a_r4_accept_goes_busy: assert property (@(posedge clk) disable iff (!por_n)
      ((wr_i || pgwr_i) && wel && !hw_rst_i && rdy_o) |=> !rdy_o);
   a_r6_abort_releases: assert property (@(posedge clk) disable iff (!por_n)
      (!rdy_o && hw_rst_i) |=> rdy_o);
   a_r8_latch_holds: assert property (@(posedge clk) disable iff (!por_n)
      (wel && !wrds_i) |=> wel);
   a_r9_viol_after_fall: assert property (@(posedge clk) disable iff (!por_n)
      viol_o |-> (!$past(cs_i) && $past(cs_i, 2)));
endmodule

bind prog_ctrl pc_checker u_pc_checker (
   .clk      (clk),
   .por_n    (por_n),
   .hw_rst_i (hw_rst_i),
   .cs_i     (cs_i),
   .wren_i   (wren_i),
   .wrds_i   (wrds_i),
   .wr_i     (wr_i),
   .pgwr_i   (pgwr_i),
   .rdy_o    (rdy_o),
   .viol_o   (viol_o),
   .wel      (wel)
);

// File: tb/tb_prog_ctrl.sv
module tb_prog_ctrl;
   localparam int PC   = 20;
   localparam int CMIN = 4;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        hw_rst_i = 1'b0, cs_i = 1'b1;
   logic        wren_i = 0, wrds_i = 0, wr_i = 0, pld_i = 0, pgwr_i = 0;
   logic [8:0]  addr_i = '0, rd_addr_i = '0;
   logic [15:0] data_i = '0;
   logic [15:0] rd_data_o;
   logic        rdy_o, viol_o;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   prog_ctrl #(.PROG_CYCLES(PC), .CS_MIN_CYC(CMIN)) dut (
      .clk(clk), .por_n(por_n), .hw_rst_i(hw_rst_i), .cs_i(cs_i),
      .wren_i(wren_i), .wrds_i(wrds_i), .wr_i(wr_i), .pld_i(pld_i),
      .pgwr_i(pgwr_i), .addr_i(addr_i), .data_i(data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .rdy_o(rdy_o),
      .viol_o(viol_o)
   );

   // behavioural reference
   bit          m_wel, m_busy, m_viol, m_csq;
   int          m_cnt, m_hi;
   logic [15:0] m_q[$];
   int          j_addr[$];
   logic [15:0] j_data[$];

   always @(posedge clk) begin
      if (!por_n) begin
         m_wel = 0; m_busy = 0; m_viol = 0; m_csq = 0; m_hi = CMIN;
         m_q.delete(); j_addr.delete(); j_data.delete();
      end else begin
         bit acc;
         acc = !m_busy && !hw_rst_i && m_wel && (wr_i || pgwr_i);
         if (m_busy) begin
            if (hw_rst_i || m_cnt == 0) m_busy = 0;
            else m_cnt--;
         end else if (acc) begin
            m_busy = 1; m_cnt = PC - 1;
            j_addr.delete(); j_data.delete();
            if (wr_i) begin
               j_addr.push_back(int'(addr_i)); j_data.push_back(data_i);
            end else begin
               foreach (m_q[i]) begin
                  j_addr.push_back(int'(addr_i) - int'(addr_i % 8) + (int'(addr_i % 8) + i) % 8);
                  j_data.push_back(m_q[i]);
               end
            end
         end
         if (wrds_i) m_wel = 0; else if (wren_i) m_wel = 1;
         if (pgwr_i) m_q.delete();
         else if (pld_i && m_q.size() < 8) m_q.push_back(data_i);
         m_viol = !cs_i && m_csq && m_hi < CMIN;
         m_hi = cs_i ? ((m_hi < CMIN) ? m_hi + 1 : CMIN) : 0;
         m_csq = cs_i;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare every clock against the reference
   always @(negedge clk) begin
      if (por_n && !done) begin
         chk(rdy_o == !m_busy, "R4/R5 rdy_o vs model", int'(rdy_o), int'(!m_busy));
         chk(viol_o == m_viol, "R9 viol_o vs model", int'(viol_o), int'(m_viol));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic cmd(input bit en, input bit ds, input bit w, input bit ld,
                      input bit pg, input logic [8:0] a, input logic [15:0] d);
      wren_i = en; wrds_i = ds; wr_i = w; pld_i = ld; pgwr_i = pg;
      addr_i = a; data_i = d;
      @(negedge clk);
      wren_i = 0; wrds_i = 0; wr_i = 0; pld_i = 0; pgwr_i = 0;
   endtask

   task automatic wait_rdy();
      for (int i = 0; i < 200 && !rdy_o; i++) @(negedge clk);
   endtask

   task automatic rd(input logic [8:0] a, input logic [15:0] exp, input string tag);
      rd_addr_i = a;
      @(negedge clk);
      chk(rd_data_o == exp, tag, int'(rd_data_o), int'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rdy_o == 1'b1, "R1 reset rdy_o", int'(rdy_o), 1);
      chk(viol_o == 1'b0, "R1 reset viol_o", int'(viol_o), 0);
      // R1 no write before enable
      cmd(0,0,1,0,0, 9'd5, 16'hDEAD);
      chk(rdy_o == 1'b1, "R1 write ignored after power-up", int'(rdy_o), 1);
      // R4 normal write
      cmd(1,0,0,0,0, 0, 0);
      cmd(0,0,1,0,0, 9'd5, 16'h1234);
      chk(rdy_o == 1'b0, "R4 busy after accept", int'(rdy_o), 0);
      wait_rdy();
      rd(9'd5, 16'h1234, "R4 word committed");
      // R8 latch kept; R2 write during busy dropped; R10/R3 read during busy
      cmd(0,0,1,0,0, 9'd6, 16'h5678);
      chk(rdy_o == 1'b0, "R8 second write accepted", int'(rdy_o), 0);
      cmd(0,0,1,0,0, 9'd5, 16'h9999);
      rd(9'd5, 16'h1234, "R10 read during busy");
      // R5 chip select toggles during busy
      cs_i = 1'b0; @(negedge clk); cs_i = 1'b1; @(negedge clk);
      cs_i = 1'b0; @(negedge clk); cs_i = 1'b1;
      repeat (CMIN + 1) @(negedge clk);
      wait_rdy();
      rd(9'd6, 16'h5678, "R8 write with retained latch");
      rd(9'd5, 16'h1234, "R2 write during busy dropped");
      // R1/R2 disable then write
      cmd(0,1,0,0,0, 0, 0);
      cmd(0,0,1,0,0, 9'd5, 16'hBEEF);
      chk(rdy_o == 1'b1, "R2 write with latch clear", int'(rdy_o), 1);
      rd(9'd5, 16'h1234, "R1 disabled word unchanged");
      // R1 both strobes: disable wins
      cmd(1,1,0,0,0, 0, 0);
      cmd(0,0,1,0,0, 9'd5, 16'hBEEF);
      chk(rdy_o == 1'b1, "R1 disable wins over enable", int'(rdy_o), 1);
      // R3 enable with reset pin high; R2 write blocked by reset pin
      hw_rst_i = 1'b1;
      cmd(1,0,0,0,0, 0, 0);
      cmd(0,0,1,0,0, 9'd7, 16'hAAAA);
      chk(rdy_o == 1'b1, "R2 write with reset pin high", int'(rdy_o), 1);
      rd(9'd5, 16'h1234, "R3 read with reset pin high");
      hw_rst_i = 1'b0;
      cmd(0,0,1,0,0, 9'd7, 16'hAAAA);
      chk(rdy_o == 1'b0, "R3 enable taken while reset high", int'(rdy_o), 0);
      wait_rdy();
      rd(9'd7, 16'hAAAA, "R3 word after enable under reset");
      // R6 abort of a single word
      cmd(0,0,1,0,0, 9'd8, 16'h1111);
      repeat (5) @(negedge clk);
      hw_rst_i = 1'b1;
      @(negedge clk);
      chk(rdy_o == 1'b1, "R6 ready after abort", int'(rdy_o), 1);
      hw_rst_i = 1'b0;
      rd(9'd8, 16'hFFFF, "R6 aborted word all ones");
      rd(9'd7, 16'hAAAA, "R6 neighbour untouched");
      // R7 partial page with wrap
      cmd(0,0,1,0,0, 9'h19, 16'h4242); wait_rdy();
      cmd(0,0,0,1,0, 0, 16'hA000);
      cmd(0,0,0,1,0, 0, 16'hA001);
      cmd(0,0,0,1,0, 0, 16'hA002);
      cmd(0,0,0,0,1, 9'h1E, 0);
      chk(rdy_o == 1'b0, "R7 page write accepted", int'(rdy_o), 0);
      wait_rdy();
      rd(9'h1E, 16'hA000, "R7 page word 0");
      rd(9'h1F, 16'hA001, "R7 page word 1");
      rd(9'h18, 16'hA002, "R7 page wrap word 2");
      rd(9'h19, 16'h4242, "R7 unloaded page slot untouched");
      // R7 overfilled buffer
      cmd(0,0,1,0,0, 9'h48, 16'h7777); wait_rdy();
      for (int i = 0; i < 10; i++) cmd(0,0,0,1,0, 0, 16'hB000 + 16'(i));
      cmd(0,0,0,0,1, 9'h40, 0);
      wait_rdy();
      for (int i = 0; i < 8; i++) rd(9'h40 + 9'(i), 16'hB000 + 16'(i), "R7 full page word");
      rd(9'h48, 16'h7777, "R7 loads past eight dropped");
      // R7 buffer emptied by a blocked page write
      cmd(0,0,0,1,0, 0, 16'hC000);
      cmd(0,1,0,0,0, 0, 0);
      cmd(0,0,0,0,1, 9'h60, 0);
      cmd(1,0,0,0,0, 0, 0);
      cmd(0,0,1,0,0, 9'h60, 16'h6060); wait_rdy();
      cmd(0,0,0,0,1, 9'h60, 0); wait_rdy();
      rd(9'h60, 16'h6060, "R7 buffer emptied by blocked request");
      // R6 page abort
      cmd(0,0,0,1,0, 0, 16'hD000);
      cmd(0,0,0,1,0, 0, 16'hD001);
      cmd(0,0,0,0,1, 9'h50, 0);
      repeat (3) @(negedge clk);
      hw_rst_i = 1'b1; @(negedge clk); hw_rst_i = 1'b0;
      rd(9'h50, 16'hFFFF, "R6 page abort word 0");
      rd(9'h51, 16'hFFFF, "R6 page abort word 1");
      // R9 select gaps
      cs_i = 1'b0; @(negedge clk);
      cs_i = 1'b1; repeat (2) @(negedge clk);
      cs_i = 1'b0; @(negedge clk);
      chk(viol_o == 1'b1, "R9 short gap flagged", int'(viol_o), 1);
      @(negedge clk);
      chk(viol_o == 1'b0, "R9 pulse one cycle", int'(viol_o), 0);
      cs_i = 1'b1; repeat (CMIN + 2) @(negedge clk);
      cs_i = 1'b0; @(negedge clk);
      chk(viol_o == 1'b0, "R9 long gap accepted", int'(viol_o), 0);
      cs_i = 1'b1; repeat (3) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule